// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits beside a synchronous memory bus that carries ACTIVE, WRITE and READ cycles. Each cycle carries an address field, a bank field, a data field and a reset-pin level. The decoder follows the software command sequences that a flash controller must see before it starts an operation. There are three short sequences (read configuration, read status, clear status) and four long sequences (erase, program, protect block, protect device). The long sequences share a five-cycle unlock prefix.

When a sequence completes, the decoder raises `op_valid` for one cycle with a 3-bit operation code and the bank, row, column and data values gathered along the way. These values stay on the outputs until the next completion. When a cycle breaks a sequence, the decoder pulses `abort` and drops back. If the breaking cycle is itself a valid first cycle, it starts a new sequence.

The state machine has sixteen states:

| Group | State | Waits for |
|---|---|---|
| Idle | `ST_IDLE` | a first cycle |
| After first cycle | `ST_C1` | the second cycle |
| Read configuration | `ST_CF_ROW` | the row ACTIVE |
| Read configuration | `ST_CF_COL` | the column READ |
| Read status | `ST_SR_ACT` | the ACTIVE |
| Read status | `ST_SR_RD` | the READ |
| Unlock prefix | `ST_U2` | the ACTIVE with 55h |
| Unlock prefix | `ST_U3` | the WRITE with 2Ah and data 55h |
| Unlock prefix | `ST_U4` | the ACTIVE with 80h |
| Operation select | `ST_U5` | the WRITE with data A0h |
| Erase | `ST_ER_ROW`, `ST_ER_CONF` | the row, then the confirm |
| Program | `ST_PG_ROW`, `ST_PG_DATA` | the row, then the column and data word |
| Protect | `ST_LK_ROW`, `ST_LK_DATA` | the row, then the lock key |

The transitions are as follows:

- **Start:** `ST_IDLE` goes to `ST_C1` on an ACTIVE at normal level.
- **Short select:** from `ST_C1`, a WRITE goes to `ST_CF_ROW` (90h) or `ST_SR_ACT` (70h), or completes clear status (50h). These three need the first cycle to have carried 88h.
- **Unlock entry:** from `ST_C1`, a WRITE with 55h goes to `ST_U2`.
- **Chain:** every other state moves to the next state in its chain.
- **Complete:** the last state of each chain completes and returns to `ST_IDLE`.
- **Abort:** any mismatch goes to `ST_C1` if the offending cycle is an ACTIVE at normal level, and to `ST_IDLE` otherwise.

Top module: `seqcmd_decoder`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) puts the decoder in idle and clears `op_valid`, `abort`, `op_code` and all captured outputs. A WRITE that follows a reset taken mid-sequence completes nothing and aborts nothing.
- R2: Bus kind encoding is 00 idle, 01 ACTIVE, 10 WRITE, 11 READ. Idle cycles between sequence cycles are ignored and do not change the sequence state.
- R3: Read configuration is the sequence ACTIVE 088h, WRITE 090h, ACTIVE row, READ column. The READ bank must equal the ACTIVE bank. It completes with code 1 and reports bank, row and column, with data 0.
- R4: Read status is ACTIVE 088h, WRITE 070h, ACTIVE, READ, and completes with code 2. Clear status is ACTIVE 088h, WRITE 050h, and completes with code 3 on its second cycle. Both report bank, row, column and data as 0.
- R5: The unlock prefix is, in order: an ACTIVE (any address); a WRITE with address 055h, which latches the bank; an ACTIVE with 055h; a WRITE with 02Ah and data 0055h; an ACTIVE with 080h. It is followed by a WRITE with data 00A0h whose address selects 020h erase, 040h program or 060h protect. A wrong key at any step aborts.
- R6: Erase continues with an ACTIVE row, then a WRITE with data 00D0h. It completes with code 4 and reports bank, row and data 00D0h, with column 0.
- R7: Program continues with an ACTIVE row, then a WRITE whose address is the column and whose data is the word. It completes with code 5 and reports bank, row, column and data.
- R8: Protect continues with an ACTIVE row, then a WRITE with lock data. Data 0001h completes protect block with code 6. Data 00F1h completes protect device with code 7. Any other data aborts.
- R9: Reset-pin level encoding is 00 low, 01 normal, 10 elevated. Every cycle except the last of a long sequence needs level 01. The last cycle of erase, program and protect block accepts 01 or 10. Protect device needs 10. A violation aborts.
- R10: From the third cycle of a long sequence onward, the bank field must equal the bank latched on the 055h WRITE, or the sequence aborts.
- R11: A mismatching cycle pulses `abort` for one cycle and never completes. If that cycle is an ACTIVE at level 01, it is taken as a new first cycle.
- R12: `op_valid` lasts exactly one cycle, one cycle after the completing bus cycle. `op_code`, `op_bank`, `op_row`, `op_col` and `op_data` hold until the next completion.
- R13: In idle, a WRITE, a READ or an ACTIVE at a level other than 01 is ignored, with no abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_kind | input | 2 | Cycle type: 00 idle, 01 ACTIVE, 10 WRITE, 11 READ |
| bus_addr | input | AW (12) | Address field of the cycle |
| bus_bank | input | BW (2) | Bank field of the cycle |
| bus_data | input | DW (16) | Data field of the cycle |
| rst_lvl | input | 2 | Reset-pin level: 00 low, 01 normal, 10 elevated |
| op_valid | output | 1 | One-cycle completion strobe |
| op_code | output | 3 | Operation code of the last completion |
| op_bank | output | BW (2) | Captured bank |
| op_row | output | AW (12) | Captured row |
| op_col | output | AW (12) | Captured column |
| op_data | output | DW (16) | Captured data |
| abort | output | 1 | One-cycle sequence abort strobe |

## Verification
The bench targets a mismatch that lands where a new sequence could begin. An ACTIVE 088h replacing the 02Ah WRITE must both abort and open a read status. A design that only drops to idle would lose that following command.

It drives protect device at normal level and then at elevated level. A design that ignores the level would complete the first attempt, and one that mixes up the lock keys would report code 6.

A bank change on the third unlock cycle and a wrong unlock data key must both abort. Idle cycles placed mid-sequence must not, or a design that treats idle as a mismatch would fail read configuration. An aborted sequence that follows a completion must leave the earlier outputs in place, which catches captures that update without a completion.

// File: rtl/seqcmd_pkg.sv
package seqcmd_pkg;

    typedef enum logic [1:0] {
        BUS_IDLE = 2'b00,
        BUS_ACT  = 2'b01,
        BUS_WR   = 2'b10,
        BUS_RD   = 2'b11
    } bus_kind_e;

    typedef enum logic [1:0] {
        LVL_LOW  = 2'b00,
        LVL_NORM = 2'b01,
        LVL_HIGH = 2'b10,
        LVL_BAD  = 2'b11
    } pin_lvl_e;

    typedef enum logic [2:0] {
        OP_NONE     = 3'd0,
        OP_RD_CFG   = 3'd1,
        OP_RD_STAT  = 3'd2,
        OP_CLR_STAT = 3'd3,
        OP_ERASE    = 3'd4,
        OP_PROG     = 3'd5,
        OP_LOCK_BLK = 3'd6,
        OP_LOCK_DEV = 3'd7
    } op_code_e;

    typedef enum logic [3:0] {
        ST_IDLE, ST_C1,
        ST_CF_ROW, ST_CF_COL, ST_SR_ACT, ST_SR_RD,
        ST_U2, ST_U3, ST_U4, ST_U5,
        ST_ER_ROW, ST_ER_CONF, ST_PG_ROW, ST_PG_DATA,
        ST_LK_ROW, ST_LK_DATA
    } seq_state_e;

    // key values on the bus
    localparam logic [7:0] KEY_SHORT = 8'h88;
    localparam logic [7:0] SEL_CFG   = 8'h90;
    localparam logic [7:0] SEL_STAT  = 8'h70;
    localparam logic [7:0] SEL_CLR   = 8'h50;
    localparam logic [7:0] UNL_A     = 8'h55;
    localparam logic [7:0] UNL_B     = 8'h2A;
    localparam logic [7:0] UNL_C     = 8'h80;
    localparam logic [7:0] UNL_DATA  = 8'h55;
    localparam logic [7:0] OPEN_DATA = 8'hA0;
    localparam logic [7:0] SEL_ER    = 8'h20;
    localparam logic [7:0] SEL_PG    = 8'h40;
    localparam logic [7:0] SEL_LK    = 8'h60;
    localparam logic [7:0] CONF_ER   = 8'hD0;
    localparam logic [7:0] LK_BLK    = 8'h01;
    localparam logic [7:0] LK_DEV    = 8'hF1;

    typedef struct packed {
        logic is_idle;
        logic is_act;
        logic is_wr;
        logic is_rd;
        logic a_short;
        logic a_cfg;
        logic a_stat;
        logic a_clr;
        logic a_unl_a;
        logic a_unl_b;
        logic a_unl_c;
        logic a_er;
        logic a_pg;
        logic a_lk;
        logic d_unl;
        logic d_open;
        logic d_conf;
        logic d_lk_blk;
        logic d_lk_dev;
        logic lv_norm;
        logic lv_high;
        logic bank_eq;
    } cyc_flags_t;

endpackage

// File: rtl/seqcmd_match.sv
module seqcmd_match
    import seqcmd_pkg::*;
#(
    parameter int AW = 12,
    parameter int BW = 2,
    parameter int DW = 16
) (
    input  logic [1:0]    bus_kind,
    input  logic [AW-1:0] bus_addr,
    input  logic [BW-1:0] bus_bank,
    input  logic [DW-1:0] bus_data,
    input  logic [1:0]    rst_lvl,
    input  logic [BW-1:0] bank_ref,
    output cyc_flags_t    flags
);

    always_comb begin
        flags.is_idle  = (bus_kind == BUS_IDLE);
        flags.is_act   = (bus_kind == BUS_ACT);
        flags.is_wr    = (bus_kind == BUS_WR);
        flags.is_rd    = (bus_kind == BUS_RD);
        flags.a_short  = (bus_addr == AW'(KEY_SHORT));
        flags.a_cfg    = (bus_addr == AW'(SEL_CFG));
        flags.a_stat   = (bus_addr == AW'(SEL_STAT));
        flags.a_clr    = (bus_addr == AW'(SEL_CLR));
        flags.a_unl_a  = (bus_addr == AW'(UNL_A));
        flags.a_unl_b  = (bus_addr == AW'(UNL_B));
        flags.a_unl_c  = (bus_addr == AW'(UNL_C));
        flags.a_er     = (bus_addr == AW'(SEL_ER));
        flags.a_pg     = (bus_addr == AW'(SEL_PG));
        flags.a_lk     = (bus_addr == AW'(SEL_LK));
        flags.d_unl    = (bus_data == DW'(UNL_DATA));
        flags.d_open   = (bus_data == DW'(OPEN_DATA));
        flags.d_conf   = (bus_data == DW'(CONF_ER));
        flags.d_lk_blk = (bus_data == DW'(LK_BLK));
        flags.d_lk_dev = (bus_data == DW'(LK_DEV));
        flags.lv_norm  = (rst_lvl == LVL_NORM);
        flags.lv_high  = (rst_lvl == LVL_HIGH);
        flags.bank_eq  = (bus_bank == bank_ref);
    end

endmodule

// File: rtl/seqcmd_fsm.sv
module seqcmd_fsm
    import seqcmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  cyc_flags_t f,
    output logic       done,
    output logic       clr,
    output logic       ld_bank,
    output logic       ld_row,
    output logic       take_col,
    output logic       take_data,
    output logic       valid_q,
    output op_code_e   code_q,
    output logic       abort_q
);

    seq_state_e st, nxt;
    logic       is88_q;
    logic       bad;
    logic       go_c1;
    op_code_e   fin;
    logic       fin_lv;

    assign fin_lv = f.lv_norm | f.lv_high;
    assign done   = (fin != OP_NONE);

    always_comb begin
        nxt       = st;
        fin       = OP_NONE;
        bad       = 1'b0;
        go_c1     = 1'b0;
        clr       = 1'b0;
        ld_bank   = 1'b0;
        ld_row    = 1'b0;
        take_col  = 1'b0;
        take_data = 1'b0;
        if (!f.is_idle) begin
            unique case (st)
                ST_IDLE: ;
                ST_C1: begin
                    if (f.is_wr && f.lv_norm) begin
                        if (is88_q && f.a_cfg)       nxt = ST_CF_ROW;
                        else if (is88_q && f.a_stat) nxt = ST_SR_ACT;
                        else if (is88_q && f.a_clr) begin
                            fin = OP_CLR_STAT;
                            nxt = ST_IDLE;
                        end else if (f.a_unl_a) begin
                            nxt     = ST_U2;
                            ld_bank = 1'b1;
                        end else bad = 1'b1;
                    end else bad = 1'b1;
                end
                ST_CF_ROW: begin
                    if (f.is_act && f.lv_norm) begin
                        nxt     = ST_CF_COL;
                        ld_bank = 1'b1;
                        ld_row  = 1'b1;
                    end else bad = 1'b1;
                end
                ST_CF_COL: begin
                    if (f.is_rd && f.lv_norm && f.bank_eq) begin
                        fin      = OP_RD_CFG;
                        take_col = 1'b1;
                        nxt      = ST_IDLE;
                    end else bad = 1'b1;
                end
                ST_SR_ACT: begin
                    if (f.is_act && f.lv_norm) nxt = ST_SR_RD;
                    else bad = 1'b1;
                end
                ST_SR_RD: begin
                    if (f.is_rd && f.lv_norm) begin
                        fin = OP_RD_STAT;
                        nxt = ST_IDLE;
                    end else bad = 1'b1;
                end
                ST_U2: begin
                    if (f.is_act && f.lv_norm && f.bank_eq && f.a_unl_a) nxt = ST_U3;
                    else bad = 1'b1;
                end
                ST_U3: begin
                    if (f.is_wr && f.lv_norm && f.bank_eq && f.a_unl_b && f.d_unl) nxt = ST_U4;
                    else bad = 1'b1;
                end
                ST_U4: begin
                    if (f.is_act && f.lv_norm && f.bank_eq && f.a_unl_c) nxt = ST_U5;
                    else bad = 1'b1;
                end
                ST_U5: begin
                    if (f.is_wr && f.lv_norm && f.bank_eq && f.d_open) begin
                        if (f.a_er)      nxt = ST_ER_ROW;
                        else if (f.a_pg) nxt = ST_PG_ROW;
                        else if (f.a_lk) nxt = ST_LK_ROW;
                        else bad = 1'b1;
                    end else bad = 1'b1;
                end
                ST_ER_ROW, ST_PG_ROW, ST_LK_ROW: begin
                    if (f.is_act && f.lv_norm && f.bank_eq) begin
                        ld_row = 1'b1;
                        nxt    = (st == ST_ER_ROW) ? ST_ER_CONF :
                                 (st == ST_PG_ROW) ? ST_PG_DATA : ST_LK_DATA;
                    end else bad = 1'b1;
                end
                ST_ER_CONF: begin
                    if (f.is_wr && f.bank_eq && fin_lv && f.d_conf) begin
                        fin       = OP_ERASE;
                        take_data = 1'b1;
                        nxt       = ST_IDLE;
                    end else bad = 1'b1;
                end
                ST_PG_DATA: begin
                    if (f.is_wr && f.bank_eq && fin_lv) begin
                        fin       = OP_PROG;
                        take_col  = 1'b1;
                        take_data = 1'b1;
                        nxt       = ST_IDLE;
                    end else bad = 1'b1;
                end
                ST_LK_DATA: begin
                    if (f.is_wr && f.bank_eq && f.d_lk_blk && fin_lv) begin
                        fin       = OP_LOCK_BLK;
                        take_data = 1'b1;
                        nxt       = ST_IDLE;
                    end else if (f.is_wr && f.bank_eq && f.d_lk_dev && f.lv_high) begin
                        fin       = OP_LOCK_DEV;
                        take_data = 1'b1;
                        nxt       = ST_IDLE;
                    end else bad = 1'b1;
                end
                default: nxt = ST_IDLE;
            endcase
            if (bad || st == ST_IDLE) begin
                if (f.is_act && f.lv_norm) begin
                    nxt   = ST_C1;
                    go_c1 = 1'b1;
                    clr   = 1'b1;
                end else begin
                    nxt = ST_IDLE;
                end
            end
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            is88_q <= 1'b0;
        end else begin
            st <= nxt;
            if (go_c1) is88_q <= f.a_short;
        end
    end

    // output register
    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            abort_q <= 1'b0;
            code_q  <= OP_NONE;
        end else begin
            valid_q <= done;
            abort_q <= bad;
            if (done) code_q <= fin;
        end
    end

    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (st == ST_IDLE && !valid_q && !abort_q)); // R1
    AST_NO_VALID_WITH_ABORT: assert property (@(posedge clk) disable iff (rst)
        !(valid_q && abort_q)); // R11
    AST_IDLE_NO_ABORT: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE) |=> !abort_q); // R13
    AST_VALID_HAS_CODE: assert property (@(posedge clk) disable iff (rst)
        valid_q |-> (code_q != OP_NONE)); // R12

endmodule

// File: rtl/seqcmd_capture.sv
module seqcmd_capture #(
    parameter int AW = 12,
    parameter int BW = 2,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          ld_bank,
    input  logic          ld_row,
    input  logic          done,
    input  logic          take_col,
    input  logic          take_data,
    input  logic [AW-1:0] bus_addr,
    input  logic [BW-1:0] bus_bank,
    input  logic [DW-1:0] bus_data,
    output logic [BW-1:0] wk_bank,
    output logic [BW-1:0] op_bank,
    output logic [AW-1:0] op_row,
    output logic [AW-1:0] op_col,
    output logic [DW-1:0] op_data
);

    logic [AW-1:0] wk_row;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wk_bank <= '0;
            wk_row  <= '0;
        end else begin
            if (ld_bank) wk_bank <= bus_bank;
            if (ld_row)  wk_row  <= bus_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            op_bank <= '0;
            op_row  <= '0;
            op_col  <= '0;
            op_data <= '0;
        end else if (done) begin
            op_bank <= wk_bank;
            op_row  <= wk_row;
            op_col  <= take_col  ? bus_addr : '0;
            op_data <= take_data ? bus_data : '0;
        end
    end

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !done |=> ($stable(op_bank) && $stable(op_row) && $stable(op_col) && $stable(op_data))); // R12

endmodule

// File: rtl/seqcmd_decoder.sv
module seqcmd_decoder
    import seqcmd_pkg::*;
#(
    parameter int AW = 12,
    parameter int BW = 2,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    bus_kind,
    input  logic [AW-1:0] bus_addr,
    input  logic [BW-1:0] bus_bank,
    input  logic [DW-1:0] bus_data,
    input  logic [1:0]    rst_lvl,
    output logic          op_valid,
    output logic [2:0]    op_code,
    output logic [BW-1:0] op_bank,
    output logic [AW-1:0] op_row,
    output logic [AW-1:0] op_col,
    output logic [DW-1:0] op_data,
    output logic          abort
);

    cyc_flags_t    flags;
    logic [BW-1:0] wk_bank;
    logic          done, clr, ld_bank, ld_row, take_col, take_data;
    op_code_e      code_q;

    seqcmd_match #(.AW(AW), .BW(BW), .DW(DW)) u_match (
        .bus_kind (bus_kind),
        .bus_addr (bus_addr),
        .bus_bank (bus_bank),
        .bus_data (bus_data),
        .rst_lvl  (rst_lvl),
        .bank_ref (wk_bank),
        .flags    (flags)
    );

    seqcmd_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .f         (flags),
        .done      (done),
        .clr       (clr),
        .ld_bank   (ld_bank),
        .ld_row    (ld_row),
        .take_col  (take_col),
        .take_data (take_data),
        .valid_q   (op_valid),
        .code_q    (code_q),
        .abort_q   (abort)
    );

    seqcmd_capture #(.AW(AW), .BW(BW), .DW(DW)) u_cap (
        .clk       (clk),
        .rst       (rst),
        .clr       (clr),
        .ld_bank   (ld_bank),
        .ld_row    (ld_row),
        .done      (done),
        .take_col  (take_col),
        .take_data (take_data),
        .bus_addr  (bus_addr),
        .bus_bank  (bus_bank),
        .bus_data  (bus_data),
        .wk_bank   (wk_bank),
        .op_bank   (op_bank),
        .op_row    (op_row),
        .op_col    (op_col),
        .op_data   (op_data)
    );

    assign op_code = code_q;

    AST_ONE_CYCLE_VALID: assert property (@(posedge clk) disable iff (rst)
        op_valid |=> !op_valid); // R12
    AST_DEV_NEEDS_HIGH: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == 3'd7) |-> ($past(rst_lvl) == 2'b10)); // R9

endmodule

// File: tb/sim_seqcmd_decoder.sv
module sim_seqcmd_decoder;

    localparam int CLK_PERIOD = 10;
    localparam logic [1:0] K_I = 2'b00, K_A = 2'b01, K_W = 2'b10, K_R = 2'b11;
    localparam logic [1:0] L_LOW = 2'b00, L_N = 2'b01, L_H = 2'b10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  kind = K_I;
    logic [11:0] addr = '0;
    logic [1:0]  bank = '0;
    logic [15:0] data = '0;
    logic [1:0]  lvl  = L_N;
    logic        op_valid, abort;
    logic [2:0]  op_code;
    logic [1:0]  op_bank;
    logic [11:0] op_row, op_col;
    logic [15:0] op_data;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    seqcmd_decoder u0 (
        .clk(clk), .rst(rst), .bus_kind(kind), .bus_addr(addr), .bus_bank(bank),
        .bus_data(data), .rst_lvl(lvl), .op_valid(op_valid), .op_code(op_code),
        .op_bank(op_bank), .op_row(op_row), .op_col(op_col), .op_data(op_data),
        .abort(abort)
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic cyc(input logic [1:0] k, input logic [11:0] a, input logic [1:0] b,
                       input logic [15:0] d, input logic [1:0] l);
        kind = k; addr = a; bank = b; data = d; lvl = l;
        @(negedge clk);
    endtask

    task automatic do_reset();
        kind = K_I; rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic expect_op(input string req, input logic [2:0] c, input logic [1:0] b,
                             input logic [11:0] r, input logic [11:0] col, input logic [15:0] d);
        check(req, "op_valid", 32'(op_valid), 1);
        check(req, "abort", 32'(abort), 0);
        check(req, "op_code", 32'(op_code), 32'(c));
        check(req, "op_bank", 32'(op_bank), 32'(b));
        check(req, "op_row", 32'(op_row), 32'(r));
        check(req, "op_col", 32'(op_col), 32'(col));
        check(req, "op_data", 32'(op_data), 32'(d));
    endtask

    task automatic expect_quiet(input string req);
        check(req, "op_valid", 32'(op_valid), 0);
        check(req, "abort", 32'(abort), 0);
    endtask

    task automatic expect_abort(input string req);
        check(req, "op_valid", 32'(op_valid), 0);
        check(req, "abort", 32'(abort), 1);
    endtask

    task automatic unlock(input logic [1:0] b);
        cyc(K_A, 12'h3C5, b, 16'h0, L_N);
        cyc(K_W, 12'h055, b, 16'h0, L_N);
        cyc(K_A, 12'h055, b, 16'h0, L_N);
        cyc(K_W, 12'h02A, b, 16'h0055, L_N);
        cyc(K_A, 12'h080, b, 16'h0, L_N);
    endtask

    task automatic t_reset();
        check("R1", "op_valid", 32'(op_valid), 0);
        check("R1", "abort", 32'(abort), 0);
        check("R1", "op_code", 32'(op_code), 0);
        check("R1", "op_data", 32'(op_data), 0);
        do_reset();
        cyc(K_A, 12'h088, 2'd0, 16'h0, L_N);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        cyc(K_W, 12'h050, 2'd0, 16'h0, L_N);
        expect_quiet("R1");
    endtask

    task automatic t_rd_cfg();
        do_reset();
        cyc(K_A, 12'h088, 2'd0, 16'h0, L_N);
        cyc(K_I, 12'h000, 2'd0, 16'h0, L_N);   // R2 idle gap
        cyc(K_W, 12'h090, 2'd0, 16'h0, L_N);
        cyc(K_I, 12'h7FF, 2'd3, 16'hFFFF, L_LOW);
        cyc(K_A, 12'h123, 2'd2, 16'h0, L_N);
        cyc(K_R, 12'h045, 2'd2, 16'h0, L_N);
        expect_op("R3", 3'd1, 2'd2, 12'h123, 12'h045, 16'h0);
        cyc(K_I, 12'h0, 2'd0, 16'h0, L_N);
        check("R12", "op_valid", 32'(op_valid), 0);
        cyc(K_A, 12'h088, 2'd0, 16'h0, L_N);
        cyc(K_W, 12'h033, 2'd0, 16'h0, L_N);
        expect_abort("R11");
        check("R12", "op_code held", 32'(op_code), 1);
        check("R12", "op_row held", 32'(op_row), 32'h123);
        check("R12", "op_col held", 32'(op_col), 32'h045);
        // READ bank differs from ACTIVE bank
        cyc(K_A, 12'h088, 2'd0, 16'h0, L_N);
        cyc(K_W, 12'h090, 2'd0, 16'h0, L_N);
        cyc(K_A, 12'h010, 2'd1, 16'h0, L_N);
        cyc(K_R, 12'h020, 2'd3, 16'h0, L_N);
        expect_abort("R3");
    endtask

    task automatic t_status();
        do_reset();
        cyc(K_A, 12'h088, 2'd1, 16'h0, L_N);
        cyc(K_W, 12'h070, 2'd1, 16'h0, L_N);
        cyc(K_A, 12'h000, 2'd1, 16'h0, L_N);
        cyc(K_R, 12'h000, 2'd1, 16'h0, L_N);
        expect_op("R4", 3'd2, 2'd0, 12'h0, 12'h0, 16'h0);
        cyc(K_A, 12'h088, 2'd0, 16'h0, L_N);
        cyc(K_W, 12'h050, 2'd0, 16'h0, L_N);
        expect_op("R4", 3'd3, 2'd0, 12'h0, 12'h0, 16'h0);
    endtask

    task automatic t_erase();
        do_reset();
        unlock(2'd1);
        expect_quiet("R5");
        cyc(K_W, 12'h020, 2'd1, 16'h00A0, L_N);
        cyc(K_A, 12'h2AB, 2'd1, 16'h0, L_N);
        cyc(K_W, 12'h000, 2'd1, 16'h00D0, L_H);
        expect_op("R6", 3'd4, 2'd1, 12'h2AB, 12'h0, 16'h00D0);
    endtask

    task automatic t_program();
        do_reset();
        unlock(2'd3);
        cyc(K_W, 12'h040, 2'd3, 16'h00A0, L_N);
        cyc(K_A, 12'h011, 2'd3, 16'h0, L_N);
        cyc(K_I, 12'h0, 2'd0, 16'h0, L_N);
        cyc(K_W, 12'h0F0, 2'd3, 16'hBEEF, L_N);
        expect_op("R7", 3'd5, 2'd3, 12'h011, 12'h0F0, 16'hBEEF);
    endtask

    task automatic t_protect();
        do_reset();
        unlock(2'd2);
        cyc(K_W, 12'h060, 2'd2, 16'h00A0, L_N);
        cyc(K_A, 12'h077, 2'd2, 16'h0, L_N);
        cyc(K_W, 12'h000, 2'd2, 16'h0001, L_N);
        expect_op("R8", 3'd6, 2'd2, 12'h077, 12'h0, 16'h0001);
        do_reset();
        unlock(2'd2);
        cyc(K_W, 12'h060, 2'd2, 16'h00A0, L_N);
        cyc(K_A, 12'h000, 2'd2, 16'h0, L_N);
        cyc(K_W, 12'h000, 2'd2, 16'h00F1, L_N);
        expect_abort("R9");
        do_reset();
        unlock(2'd2);
        cyc(K_W, 12'h060, 2'd2, 16'h00A0, L_N);
        cyc(K_A, 12'h000, 2'd2, 16'h0, L_N);
        cyc(K_W, 12'h000, 2'd2, 16'h00F1, L_H);
        check("R8", "op_valid", 32'(op_valid), 1);
        check("R8", "op_code", 32'(op_code), 7);
        check("R8", "op_data", 32'(op_data), 32'h00F1);
    endtask

    task automatic t_bank_and_keys();
        do_reset();
        cyc(K_A, 12'h100, 2'd1, 16'h0, L_N);
        cyc(K_W, 12'h055, 2'd1, 16'h0, L_N);
        cyc(K_A, 12'h055, 2'd2, 16'h0, L_N);
        expect_abort("R10");
        do_reset();
        cyc(K_A, 12'h100, 2'd0, 16'h0, L_N);
        cyc(K_W, 12'h055, 2'd0, 16'h0, L_N);
        cyc(K_A, 12'h055, 2'd0, 16'h0, L_N);
        cyc(K_W, 12'h02A, 2'd0, 16'h0054, L_N);
        expect_abort("R5");
        cyc(K_I, 12'h0, 2'd0, 16'h0, L_N);
        check("R11", "abort one cycle", 32'(abort), 0);
    endtask

    task automatic t_abort_restart();
        do_reset();
        cyc(K_A, 12'h100, 2'd0, 16'h0, L_N);
        cyc(K_W, 12'h055, 2'd0, 16'h0, L_N);
        cyc(K_A, 12'h055, 2'd0, 16'h0, L_N);
        cyc(K_A, 12'h088, 2'd0, 16'h0, L_N);
        expect_abort("R11");
        cyc(K_W, 12'h070, 2'd0, 16'h0, L_N);
        cyc(K_A, 12'h000, 2'd0, 16'h0, L_N);
        cyc(K_R, 12'h000, 2'd0, 16'h0, L_N);
        check("R11", "op_valid after restart", 32'(op_valid), 1);
        check("R11", "op_code after restart", 32'(op_code), 2);
    endtask

    task automatic t_levels();
        do_reset();
        cyc(K_A, 12'h088, 2'd0, 16'h0, L_N);
        cyc(K_W, 12'h090, 2'd0, 16'h0, L_LOW);
        expect_abort("R9");
        do_reset();
        cyc(K_A, 12'h088, 2'd0, 16'h0, L_LOW);
        expect_quiet("R13");
        cyc(K_W, 12'h070, 2'd0, 16'h0, L_N);
        expect_quiet("R13");
        cyc(K_R, 12'h000, 2'd0, 16'h0, L_N);
        expect_quiet("R13");
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_err++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_rd_cfg();
        t_status();
        t_erase();
        t_program();
        t_protect();
        t_bank_and_keys();
        t_abort_restart();
        t_levels();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule